// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

This block gives a chip an 8-bit general-purpose I/O port that software reaches over a small synchronous register bus. It holds an output data latch and a per-bit direction register. It also presents a read-only pin-state view. Each pin drives its latch bit when its direction bit is 1. When the direction bit is 0 the pin is not driven. The pin-state view lets software observe the port. A pin set as an output reads back the value the port is driving. A pin set as an input reads back its level after a two-flop synchronizer.

The block supports two low-power modes with opposite effects on state. Hardware standby clears the data and direction registers, in the same way as reset. Software standby freezes every register, including the synchronizer and therefore the pin-state view. Bus writes are ignored in both modes. When both modes are asserted, hardware standby wins.

Bus reads are registered. Read data appears one clock after the address is presented. The address map is: 0 = output data (read/write), 1 = direction (write-only), 2 = pin state (read-only), 3 = unmapped.

Top module: `gport_top`

## Requirements
- R1: A bus write to address 0 loads the output data register on the next clock edge. A read of address 0 returns that register's value on `busRdData` one clock after the address is presented.
- R2: `pinOe[i]` equals direction bit i and `pinOut[i]` equals data bit i at all times. A pin whose `pinOe` is 0 is treated as high impedance.
- R3: A bus write to address 1 loads the direction register, which takes effect on the next clock edge. Reads of address 1 always return 0x00.
- R4: A read of address 2 returns bit i of the data register where direction bit i is 1. Where direction bit i is 0, it returns `pinIn[i]` as sampled through two synchronizer flops, so an input change is visible two clocks later.
- R5: Bus writes to address 2 or address 3 change no register. Reads of address 3 return 0x00.
- R6: While `rst_n` is low, the data register, the direction register, the synchronizer and `busRdData` are all 0.
- R7: While `hwStandby` is 1, the data and direction registers are cleared to 0 and bus writes are ignored. The synchronizer keeps tracking the pins.
- R8: While `swStandby` is 1 and `hwStandby` is 0, the data register, the direction register and the synchronizer hold their values, so the pin-state view is frozen. Bus writes are ignored.
- R9: When `hwStandby` and `swStandby` are both 1, the hardware standby behaviour of R7 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hwStandby | input | 1 | Hardware standby: clears the registers |
| swStandby | input | 1 | Software standby: freezes the registers |
| busWr | input | 1 | Write strobe for the current address |
| busAddr | input | 2 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Registered read data for the previous cycle's address |
| pinIn | input | 8 | Levels sensed on the port pins |
| pinOut | output | 8 | Values driven on the port pins |
| pinOe | output | 8 | Per-pin output enable |

## Verification
Assertions check the following on every cycle:
- the standby-mode register effects (clearing under hardware standby, holding under software standby);
- the suppression of writes in either standby mode and at unmapped addresses;
- the precedence of hardware standby;
- the read results for the data and direction addresses.

The per-bit merge in the pin-state view needs the bench's scenarios. So does the two-clock lag from pin to readback, and the frozen view while input pins change under software standby. The bench compares every output against a behavioural model on each clock to cover these.

// File: rtl/gport_pkg.sv
package gport_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PINS = 2'd2,
    SEL_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic clearRegs;
    logic holdAll;
  } portStrobe_t;

endpackage

// File: rtl/gport_ctrl.sv
module gport_ctrl
  import gport_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_ADDR = 0,
  parameter int DIR_ADDR  = 1,
  parameter int PIN_ADDR  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output portStrobe_t       strobe,
  output rdSel_e            rdSel
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_ADDR);
  localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(PIN_ADDR);

  logic busLive;

  // Hardware standby takes precedence: it clears and never freezes.
  assign busLive = busWr && !hwStandby && !swStandby;

  always_comb begin
    strobe.clearRegs = hwStandby;
    strobe.holdAll   = swStandby && !hwStandby;
    strobe.wrData    = busLive && (busAddr == A_DATA);
    strobe.wrDir     = busLive && (busAddr == A_DIR);
  end

  always_comb begin
    if (busAddr == A_DATA)     rdSel = SEL_DATA;
    else if (busAddr == A_DIR) rdSel = SEL_DIR;
    else if (busAddr == A_PIN) rdSel = SEL_PINS;
    else                       rdSel = SEL_NONE;
  end

  AST_NO_STANDBY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (hwStandby || swStandby) |-> !(strobe.wrData || strobe.wrDir)); // R7
  AST_HW_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (hwStandby && swStandby) |-> (strobe.clearRegs && !strobe.holdAll)); // R9
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr != A_DATA && busAddr != A_DIR) |-> !(strobe.wrData || strobe.wrDir)); // R5
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.wrData, strobe.wrDir})); // R1

endmodule

// File: rtl/gport_datapath.sv
module gport_datapath
  import gport_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  portStrobe_t      strobe,
  input  rdSel_e           rdSel,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] rdData
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] dataQ;
  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] pinView;
  logic [WIDTH-1:0] rdNext;
  logic [WIDTH-1:0] rdQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataQ <= '0;
      dirQ  <= '0;
    end else if (strobe.clearRegs) begin
      dataQ <= '0;
      dirQ  <= '0;
    end else if (!strobe.holdAll) begin
      if (strobe.wrData) dataQ <= wrData;
      if (strobe.wrDir)  dirQ  <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else if (!strobe.holdAll) begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign pinView[b] = dirQ[b] ? dataQ[b] : syncQ[LAST][b];
  end

  always_comb begin
    unique case (rdSel)
      SEL_DATA: rdNext = dataQ;
      SEL_PINS: rdNext = pinView;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdQ <= '0;
    else        rdQ <= rdNext;
  end

  assign pinOut = dataQ;
  assign pinOe  = dirQ;
  assign rdData = rdQ;

  AST_HW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clearRegs |=> (dataQ == '0 && dirQ == '0)); // R7
  AST_SW_HOLDS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.holdAll |=> ($stable(dataQ) && $stable(dirQ))); // R8
  AST_SW_HOLDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.holdAll |=> $stable(syncQ[LAST])); // R8
  AST_DIR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdSel == SEL_DIR) |=> (rdData == '0)); // R3
  AST_DATA_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rdSel == SEL_DATA && !strobe.clearRegs) |=> (rdData == $past(dataQ))); // R1
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdSel == SEL_NONE) |=> (rdData == '0)); // R5

endmodule

// File: rtl/gport_top.sv
module gport_top
  import gport_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe
);

  portStrobe_t strobe;
  rdSel_e      rdSel;

  gport_ctrl #(
    .ADDR_W(ADDR_W), .DATA_ADDR(0), .DIR_ADDR(1), .PIN_ADDR(2)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hwStandby(hwStandby), .swStandby(swStandby),
    .busWr(busWr), .busAddr(busAddr), .strobe(strobe), .rdSel(rdSel)
  );

  gport_datapath #(
    .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdSel(rdSel),
    .wrData(busWrData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .rdData(busRdData)
  );

endmodule

// File: tb/gport_top_test.sv
module gport_top_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hwStandby = 1'b0;
  logic       swStandby = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] pinIn = 8'h00;
  logic [7:0] busRdData, pinOut, pinOe;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    finished = 1'b0;
  string curReq = "R6";

  // behavioural reference state
  logic [7:0] mDat = 8'h00, mDir = 8'h00, mS1 = 8'h00, mS2 = 8'h00, mRd = 8'h00;

  gport_top uut (
    .clk(clk), .rst_n(rst_n), .hwStandby(hwStandby), .swStandby(swStandby),
    .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    logic [7:0] view;
    logic [7:0] rdN;
    if (!rst_n) begin
      mDat = 0; mDir = 0; mS1 = 0; mS2 = 0; mRd = 0;
    end else begin
      view = 8'h00;
      for (int b = 0; b < 8; b++) view[b] = mDir[b] ? mDat[b] : mS2[b];
      case (busAddr)
        2'd0:    rdN = mDat;
        2'd2:    rdN = view;
        default: rdN = 8'h00;
      endcase
      mRd = rdN;
      if (hwStandby) begin
        mDat = 0; mDir = 0;
        mS2 = mS1; mS1 = pinIn;
      end else if (!swStandby) begin
        if (busWr && busAddr == 2'd0) mDat = busWrData;
        if (busWr && busAddr == 2'd1) mDir = busWrData;
        mS2 = mS1; mS1 = pinIn;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      cycles++;
      checks++;
      if (pinOut !== mDat) begin
        failures++;
        $display("FAIL R2/%s pinOut actual=%h expected=%h", curReq, pinOut, mDat);
      end
      checks++;
      if (pinOe !== mDir) begin
        failures++;
        $display("FAIL R2/%s pinOe actual=%h expected=%h", curReq, pinOe, mDir);
      end
      checks++;
      if (busRdData !== mRd) begin
        failures++;
        $display("FAIL %s busRdData actual=%h expected=%h", curReq, busRdData, mRd);
      end
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<20000", cycles);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    step(1);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    busAddr = a;
    step(2);
  endtask

  initial begin
    // R6: reset state
    curReq = "R6"; pinIn = 8'hFF;
    step(4);
    rst_n = 1'b1;
    step(1);
    // R1: data register write and readback
    curReq = "R1";
    wr(2'd0, 8'hA5); rd(2'd0);
    wr(2'd0, 8'h5A); rd(2'd0);
    // R3: direction write, reads as zero
    curReq = "R3";
    wr(2'd1, 8'h0F); rd(2'd1);
    // R4: merged pin view under several pin patterns, with two-clock lag
    curReq = "R4";
    busAddr = 2'd2;
    for (int i = 0; i < 8; i++) begin
      pinIn = 8'h3C ^ (8'h11 << i);
      step(1);
    end
    wr(2'd1, 8'hF0); busAddr = 2'd2; pinIn = 8'hC3; step(4);
    wr(2'd1, 8'h00); busAddr = 2'd2; pinIn = 8'h96; step(4);
    // R5: writes to pin-state and unmapped addresses ignored
    curReq = "R5";
    wr(2'd1, 8'hAA);
    wr(2'd2, 8'hFF); wr(2'd3, 8'h00); rd(2'd0); rd(2'd3); rd(2'd2);
    // R7: hardware standby clears and blocks writes
    curReq = "R7";
    hwStandby = 1'b1;
    wr(2'd0, 8'h77); wr(2'd1, 8'h77);
    busAddr = 2'd2; pinIn = 8'h18; step(3);
    hwStandby = 1'b0; rd(2'd0); rd(2'd2);
    // R8: software standby freezes registers and pin view
    curReq = "R8";
    wr(2'd0, 8'hC6); wr(2'd1, 8'h0F);
    busAddr = 2'd2; step(3);
    swStandby = 1'b1;
    pinIn = 8'hE7; wr(2'd0, 8'h11); wr(2'd1, 8'hFF);
    busAddr = 2'd2; step(4);
    swStandby = 1'b0; step(4);
    // R9: both standby inputs, hardware wins
    curReq = "R9";
    swStandby = 1'b1; hwStandby = 1'b1;
    pinIn = 8'h42; wr(2'd0, 8'h99);
    busAddr = 2'd2; step(4);
    hwStandby = 1'b0; swStandby = 1'b0; rd(2'd0); rd(2'd2);
    // R6: reset mid-run
    curReq = "R6";
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    rst_n = 1'b0; step(3); rst_n = 1'b1; step(2);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule